// File: doc/BRIEF.md
# PCI Expansion ROM Window and Interrupt Configuration Registers

This block holds two 32-bit words of a PCI configuration header. The first is the expansion ROM window register. Configuration software writes a base address into its upper bits and sets a low-order enable bit. A size code chosen at integration time fixes how many base bits can be written. The other base bits read back as zero. The block drives the decoded ROM base and a decode-enable flag to a ROM address decoder that sits outside this block. Decoding happens only when the command register's memory-space bit is also set.

The second word holds the interrupt and bus-timing fields. The two upper bytes give the maximum latency and the minimum grant. An EEPROM autoloader fills them through a parallel load strobe before it signals completion. Until that completion flag arrives, any host access to this word is answered with retry. The interrupt pin byte is fixed, and the interrupt line byte is a plain read/write scratch value.

The configuration port carries no handshake and no back-pressure. Read data and retry are combinational in the cycle in which `cfg_rd` or `cfg_wr` is high, and a write takes effect at the next rising clock edge. The EEPROM load interface is a plain strobe with no ready signal: every strobe seen before completion is accepted.

Top module: `pci_romint_cfg`

## Requirements
- R1: The ROM window register is at dword index 12 (byte offset 0x30). Its base field is bits 31:13, and a read returns the last value written to the bits that the size code allows. Without a write, the stored base does not change.
- R2: Bits 12:1 of the ROM window register always read as zero.
- R3: Bit 0 of the ROM window register is a read/write enable, written through byte lane 0. It reads as written whenever the size code is valid.
- R4: `rom_dec_en` is 1 only when the enable bit, `cmd_mem_en` and a valid size code are all 1.
- R5: Size code 1, 2, 3 and 4 select windows of 32, 64, 128 and 256 KB. For a window of 2^n bytes, base bits n-1 down to 13 read as zero and ignore writes. `rom_base` carries the same masked base, with bits 12:0 at zero.
- R6: Size codes 0 and 5 to 7 mean that there is no ROM. With such a code the whole ROM window register reads as zero, writes to it are ignored, and `rom_dec_en` is 0.
- R7: Each `ee_load` pulse seen before completion stores `ee_data[15:8]` into bits 31:24 (maximum latency) and `ee_data[7:0]` into bits 23:16 (minimum grant). An `ee_done` pulse latches completion. After completion, further loads are ignored, and host writes never change bits 31:16.
- R8: The interrupt word is at dword index 15 (byte offset 0x3C). While completion is not latched, a read or write of it drives `cfg_retry` high in the same cycle and returns read data 0. A write made then has no effect.
- R9: Bits 15:8 of the interrupt word read as 8'h01 (the first interrupt pin).
- R10: Bits 7:0 of the interrupt word are the read/write interrupt line, written through byte lane 0.
- R11: Byte enable bit k qualifies write-data bits 8k+7 down to 8k. Writable bits in a lane whose enable is 0 keep their value.
- R12: Reset clears the base, the enable, the interrupt line, both EEPROM fields and the completion flag. A read at any other dword index returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_rd | input | 1 | Read access this cycle |
| cfg_wr | input | 1 | Write access this cycle |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational, 0 when no read hits) |
| cfg_retry | output | 1 | Retry response to the current access |
| rom_size | input | 3 | ROM window size code |
| cmd_mem_en | input | 1 | Memory-space enable bit of the command register |
| ee_load | input | 1 | EEPROM field load strobe |
| ee_data | input | 16 | EEPROM data: max latency in 15:8, min grant in 7:0 |
| ee_done | input | 1 | EEPROM autoload complete pulse or level |
| rom_base | output | 32 | Decoded ROM base address |
| rom_dec_en | output | 1 | ROM decode enable |

## Verification
The bench builds the block with its default parameters: a 6-bit dword index, the ROM window at index 12 and the interrupt word at index 15. At this size every one of the eight size codes can be swept against both settings of the memory-space bit, with the expected mask computed as a shift of all-ones. The interrupt line is swept through all 256 values, and the retry window is checked both before the EEPROM load and again after a mid-run reset.

// File: rtl/pci_romint_pkg.sv
package pci_romint_pkg;

  localparam int DATA_W   = 32;
  localparam int BASE_LSB = 13;
  localparam int BASE_W   = DATA_W - BASE_LSB;

  typedef enum logic [2:0] {
    ROM_NONE = 3'd0,
    ROM_32K  = 3'd1,
    ROM_64K  = 3'd2,
    ROM_128K = 3'd3,
    ROM_256K = 3'd4
  } rom_size_e;

  // Mask of base bits that are writable and visible for a size code.
  function automatic logic [DATA_W-1:0] rom_base_mask(input logic [2:0] code);
    logic [DATA_W-1:0] m;
    case (rom_size_e'(code))
      ROM_32K:  m = 32'hFFFF_8000;
      ROM_64K:  m = 32'hFFFF_0000;
      ROM_128K: m = 32'hFFFE_0000;
      ROM_256K: m = 32'hFFFC_0000;
      default:  m = '0;
    endcase
    return m;
  endfunction

  // Expand byte enables into a bit mask.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [DATA_W/8-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W/8; i++) begin
      m[i*8 +: 8] = {8{be[i]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/rom_bar_reg.sv
module rom_bar_reg
  import pci_romint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        be,
  input  logic [BASE_W-1:0] wr_base,
  input  logic              wr_enable_bit,
  input  logic [2:0]        size_code,
  input  logic              cmd_mem_en,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] rom_base,
  output logic              rom_dec_en
);

  logic [BASE_W-1:0] base_q;
  logic              en_q;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] be_mask;
  logic [BASE_W-1:0] wmask;
  logic              size_ok;

  assign size_mask = rom_base_mask(size_code);
  assign size_ok   = |size_mask;
  assign be_mask   = lane_mask(be);
  assign wmask     = be_mask[DATA_W-1:BASE_LSB] & size_mask[DATA_W-1:BASE_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      base_q <= (base_q & ~wmask) | (wr_base & wmask);
      if (be[0] && size_ok) en_q <= wr_enable_bit;
    end
  end

  assign rom_base   = {base_q & size_mask[DATA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign rd_word    = {rom_base[DATA_W-1:BASE_LSB], {(BASE_LSB-1){1'b0}}, en_q & size_ok};
  assign rom_dec_en = en_q & size_ok & cmd_mem_en;

  AST_DEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rom_dec_en |-> (cmd_mem_en && size_code >= 3'd1 && size_code <= 3'd4)); // R4
  AST_WINDOW_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 3'd4) |-> (rom_base[17:0] == 18'd0)); // R5
  AST_NO_ROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 3'd0 || size_code > 3'd4) |-> (rd_word == '0 && !rom_dec_en)); // R6
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)); // R1

endmodule

// File: rtl/intr_reg.sv
module intr_reg
  import pci_romint_pkg::*;
#(
  parameter logic [7:0] PIN_CODE = 8'h01,
  parameter int         EE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              lane0_en,
  input  logic [7:0]        wr_line,
  input  logic              ee_load,
  input  logic [EE_W-1:0]   ee_data,
  input  logic              ee_done,
  output logic              loaded,
  output logic [DATA_W-1:0] rd_word
);

  localparam int HALF = EE_W / 2;

  logic [HALF-1:0] max_lat_q;
  logic [HALF-1:0] min_gnt_q;
  logic [7:0]      line_q;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      max_lat_q <= '0;
      min_gnt_q <= '0;
      line_q    <= '0;
      done_q    <= 1'b0;
    end else begin
      if (ee_load && !done_q) begin
        max_lat_q <= ee_data[EE_W-1:HALF];
        min_gnt_q <= ee_data[HALF-1:0];
      end
      if (ee_done) done_q <= 1'b1;
      if (wr_en && lane0_en && done_q) line_q <= wr_line;
    end
  end

  assign loaded  = done_q;
  assign rd_word = {max_lat_q, min_gnt_q, PIN_CODE, line_q};

  AST_EE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable({max_lat_q, min_gnt_q})); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R7
  AST_LINE_HOLD_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done_q) |=> $stable(line_q)); // R8

endmodule

// File: rtl/pci_romint_cfg.sv
module pci_romint_cfg
  import pci_romint_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         ROM_IDX  = 12,
  parameter int         INT_IDX  = 15,
  parameter logic [7:0] PIN_CODE = 8'h01,
  parameter int         EE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_retry,
  input  logic [2:0]        rom_size,
  input  logic              cmd_mem_en,
  input  logic              ee_load,
  input  logic [EE_W-1:0]   ee_data,
  input  logic              ee_done,
  output logic [31:0]       rom_base,
  output logic              rom_dec_en
);

  logic        rom_sel, int_sel;
  logic        int_loaded;
  logic [31:0] rom_word, int_word;
  logic        unused_bits;

  assign rom_sel     = (cfg_addr == ADDR_W'(ROM_IDX));
  assign int_sel     = (cfg_addr == ADDR_W'(INT_IDX));
  assign cfg_retry   = (cfg_rd || cfg_wr) && int_sel && !int_loaded;
  assign unused_bits = ^cfg_wdata[12:8];

  rom_bar_reg u_rom_bar (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_wr && rom_sel),
    .be           (cfg_be),
    .wr_base      (cfg_wdata[DATA_W-1:BASE_LSB]),
    .wr_enable_bit(cfg_wdata[0]),
    .size_code    (rom_size),
    .cmd_mem_en   (cmd_mem_en),
    .rd_word      (rom_word),
    .rom_base     (rom_base),
    .rom_dec_en   (rom_dec_en)
  );

  intr_reg #(.PIN_CODE(PIN_CODE), .EE_W(EE_W)) u_intr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr && int_sel),
    .lane0_en(cfg_be[0]),
    .wr_line (cfg_wdata[7:0]),
    .ee_load (ee_load),
    .ee_data (ee_data),
    .ee_done (ee_done),
    .loaded  (int_loaded),
    .rd_word (int_word)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_rd) begin
      if (rom_sel)                  cfg_rdata = rom_word;
      else if (int_sel && int_loaded) cfg_rdata = int_word;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && rom_sel) |-> (cfg_rdata[12:1] == 12'd0)); // R2
  AST_PIN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && int_sel && !cfg_retry) |-> (cfg_rdata[15:8] == PIN_CODE)); // R9
  AST_RETRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_retry |-> (cfg_rdata == 32'd0)); // R8

endmodule

// File: tb/pci_romint_cfg_tb_top.sv
`timescale 1ns/1ps
module pci_romint_cfg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_retry;
  logic [2:0]  rom_size = 3'd4;
  logic        cmd_mem_en = 1'b0;
  logic        ee_load = 1'b0;
  logic [15:0] ee_data = '0;
  logic        ee_done = 1'b0;
  logic [31:0] rom_base;
  logic        rom_dec_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pci_romint_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_retry(cfg_retry),
    .rom_size(rom_size), .cmd_mem_en(cmd_mem_en), .ee_load(ee_load), .ee_data(ee_data),
    .ee_done(ee_done), .rom_base(rom_base), .rom_dec_en(rom_dec_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mask(input int s);
    if (s >= 1 && s <= 4) return ~((32'd1 << (14 + s)) - 32'd1);
    return 32'd0;
  endfunction

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                           output logic rty);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    #1 rty = cfg_retry;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d, output logic rty);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    #1 d = cfg_rdata; rty = cfg_retry;
    #0.5 cfg_rd = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    logic        rty;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    cfg_read(6'd12, rd, rty);
    chk("R12 reset rom bar", rd, 32'd0);
    chk("R12 reset rom_base", rom_base, 32'd0);
    chk("R12 reset dec_en", {31'd0, rom_dec_en}, 32'd0);
    cfg_read(6'd15, rd, rty);
    chk("R8 retry before load", {31'd0, rty}, 32'd1);
    chk("R8 rdata zero on retry", rd, 32'd0);

    // R1..R6, R11: sweep every size code and both command bit values
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] m, p, e;
        logic        v;
        rom_size = 3'(s); cmd_mem_en = c[0];
        m = exp_mask(s); v = (m != 0);
        cfg_write(6'd12, 4'hF, 32'hFFFF_FFFF, rty);
        cfg_read(6'd12, rd, rty);
        chk("R5 R6 all-ones readback", rd, m | {31'd0, v});
        chk("R2 reserved bits", rd & 32'h0000_1FFE, 32'd0);
        chk("R5 rom_base mask", rom_base, m);
        chk("R4 dec_en", {31'd0, rom_dec_en}, {31'd0, v & c[0]});
        cfg_write(6'd12, 4'hF, 32'd0, rty);
        cfg_read(6'd12, rd, rty);
        chk("R3 enable cleared", rd, 32'd0);
        chk("R4 dec_en off", {31'd0, rom_dec_en}, 32'd0);
        p = 32'hA5C3_E001 ^ (32'(s) << 20);
        cfg_write(6'd12, 4'hF, p, rty);
        cfg_read(6'd12, rd, rty);
        e = (p & m) | {31'd0, v & p[0]};
        chk("R1 pattern readback", rd, e);
        cfg_write(6'd12, 4'b1000, 32'd0, rty);
        cfg_read(6'd12, rd, rty);
        chk("R11 lane3 only", rd, e & 32'h00FF_FFFF);
        cfg_write(6'd12, 4'b0110, 32'h0000_0000, rty);
        cfg_read(6'd12, rd, rty);
        chk("R11 lanes1-2 with bit0 kept", rd, e & 32'h0000_0001);
      end
    end

    // R12 unmapped offset
    rom_size = 3'd4; cmd_mem_en = 1'b1;
    cfg_write(6'd12, 4'hF, 32'h1234_0001, rty);
    cfg_write(6'd20, 4'hF, 32'hFFFF_FFFF, rty);
    cfg_read(6'd20, rd, rty);
    chk("R12 unmapped read", rd, 32'd0);
    cfg_read(6'd12, rd, rty);
    chk("R12 unmapped write no effect", rd, 32'h1234_0001 & 32'hFFFC_0001);
    chk("R4 dec_en on", {31'd0, rom_dec_en}, 32'd1);

    // R8 write before completion is retried and dropped
    cfg_write(6'd15, 4'hF, 32'hFFFF_FFFF, rty);
    chk("R8 retry on write", {31'd0, rty}, 32'd1);
    @(negedge clk); ee_load = 1'b1; ee_data = 16'hA55A;
    @(negedge clk); ee_load = 1'b0; ee_done = 1'b1;
    @(negedge clk); ee_done = 1'b0;
    cfg_read(6'd15, rd, rty);
    chk("R8 no retry after done", {31'd0, rty}, 32'd0);
    chk("R7 R9 R8 loaded word", rd, 32'hA55A_0100);

    // R10 sweep every interrupt line value
    for (int v = 0; v < 256; v++) begin
      cfg_write(6'd15, 4'h1, {24'hFFFFFF, 8'(v)}, rty);
      cfg_read(6'd15, rd, rty);
      chk("R10 line sweep", rd, {24'hA55A01, 8'(v)});
    end
    cfg_write(6'd15, 4'hE, 32'h0000_0000, rty);
    cfg_read(6'd15, rd, rty);
    chk("R11 R7 upper lanes ignored", rd, 32'hA55A_01FF);
    cfg_write(6'd15, 4'hE, 32'h0000_0033, rty);
    cfg_read(6'd15, rd, rty);
    chk("R11 lane0 disabled", rd, 32'hA55A_01FF);
    @(negedge clk); ee_load = 1'b1; ee_data = 16'h1111;
    @(negedge clk); ee_load = 1'b0;
    cfg_read(6'd15, rd, rty);
    chk("R7 load after done ignored", rd, 32'hA55A_01FF);

    // R12 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cfg_read(6'd12, rd, rty);
    chk("R12 bar cleared", rd, 32'd0);
    chk("R12 dec_en cleared", {31'd0, rom_dec_en}, 32'd0);
    cfg_read(6'd15, rd, rty);
    chk("R12 R8 retry after reset", {31'd0, rty}, 32'd1);
    @(negedge clk); ee_done = 1'b1;
    @(negedge clk); ee_done = 1'b0;
    cfg_read(6'd15, rd, rty);
    chk("R12 fields and line cleared", rd, 32'h0000_0100);

    finished = 1'b1;
    summary();
  end

endmodule